// File: doc/BRIEF.md
# Radio Transmit Serializer

This block feeds the transmit side of a radio transceiver. It pulls bytes from an external transmit byte buffer and shifts them onto a serial data pin, least significant bit first. Each bit lasts one period of a transmit bit clock. That clock is either generated here by dividing the system clock, or taken from an external pin. Every change on the data pin happens at a falling edge of the bit clock, so the transceiver can sample on the rising edge.

Around each burst the block drives a transmit-command strobe with programmable polarity. The strobe tells the transceiver to switch into transmit mode. It becomes active a programmable number of bit times before the first data bit, and it stays active a programmable number of bit times after the last one. While the line is idle, and during both ramp windows, the data pin holds a selectable level: 0, 1, or the last bit sent. Complementary copies of the data pin and of the command strobe are also provided. A force input holds the command active without starting a burst.

Top module: `rf_tx_serializer`

## Requirements
- R1: In internal clock mode (`cfg_ext_clk`=0), `txclk_oe` is 1. `txclk_out` toggles every `cfg_half`+1 system cycles, so a bit lasts 2*(`cfg_half`+1) cycles. In external mode `txclk_oe` is 0.
- R2: `txd` changes only at a falling edge of the bit clock. In internal mode it changes in the same system cycle as the falling edge of `txclk_out`, so it is stable at every rising edge.
- R3: A frame starts at a bit-clock falling edge that finds the line idle and the buffer non-empty (`buf_empty`=0). From that edge the command is active, and the ramp-up lasts `cfg_lead`+1 bit times with `txd` at the idle level.
- R4: Each byte is sent least significant bit first, one bit per bit time, with no gap between bytes. `buf_pop` is high for exactly one system cycle, at the falling edge that begins bit 0 of the byte on `buf_data`, and never while the buffer is empty.
- R5: A byte boundary that finds the buffer empty ends the data phase. A ramp-down of `cfg_lag`+1 bit times follows, with the command still active and `txd` at the idle level. The line then returns to idle with the command inactive.
- R6: The idle and ramp level of `txd` is set by `cfg_idle_mode`: 00 gives 0, 01 gives 1, and 10 or 11 gives the last data bit sent, which is 0 after reset.
- R7: `txd_n` is the inverse of `txd` while data bits are sent. It is 0 when idle and during both ramp windows.
- R8: `cfg_cmd_pol`=1 makes `txcmd` active high; 0 makes it active low. `txcmd_n` is always the complement of `txcmd`. When idle and not forced, `txcmd` is at its inactive level.
- R9: `cfg_cmd_force`=1 drives the command active whatever the state. It starts no frame and pops nothing.
- R10: In external mode (`cfg_ext_clk`=1), `txclk_in` passes through a two-flop synchronizer and its falling edges pace the frame. Frame contents follow R3 to R7, and every change of `txd` comes within three system cycles of a `txclk_in` fall.
- R11: After reset the line is idle: `txd` is at the idle level, `txd_n` is 0, the command is inactive and `buf_pop` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_clk | input | 1 | 1 selects the external bit clock |
| cfg_half | input | DIV_W | Internal half bit period minus one, in system cycles |
| cfg_idle_mode | input | 2 | Idle/ramp level select: 00 low, 01 high, 1x last bit |
| cfg_cmd_pol | input | 1 | Command polarity, 1 active high |
| cfg_cmd_force | input | 1 | Force the command active |
| cfg_lead | input | RAMP_W | Ramp-up length minus one, in bit times |
| cfg_lag | input | RAMP_W | Ramp-down length minus one, in bit times |
| buf_empty | input | 1 | Transmit buffer holds no byte |
| buf_data | input | BYTE_W | Byte at the head of the transmit buffer |
| buf_pop | output | 1 | Consume the head byte |
| txclk_in | input | 1 | External bit clock |
| txclk_out | output | 1 | Generated bit clock |
| txclk_oe | output | 1 | Drive enable for the bit clock pin |
| txd | output | 1 | Serial transmit data |
| txd_n | output | 1 | Inverted data, 0 outside the data phase |
| txcmd | output | 1 | Transmit command strobe |
| txcmd_n | output | 1 | Complement of the command strobe |

## Verification
The assertions watch several rules on every cycle: that the data pin moves only with a falling edge of the generated clock, that a buffer pop is single-cycle and lines up with such an edge and never hits an empty buffer, that the inverted data is quiet outside the data phase, and that the command level matches idle versus busy under the chosen polarity. The bench alone can show frame shape and timing. That covers ramp lengths counted in bit times, bit order across byte boundaries, the end-of-frame underflow, the idle level in each mode (including the last bit carried over between frames), the bit-clock period, and the same frames paced by an external clock.

// File: rtl/rf_tx_serializer_pkg.sv
package rf_tx_serializer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_RAMP_UP   = 2'd1,
    ST_DATA      = 2'd2,
    ST_RAMP_DOWN = 2'd3
  } tx_state_e;
endpackage

// File: rtl/rf_tx_bitclk.sv
// Bit clock source: internal divider or synchronized external pin.
// Produces a one-cycle strobe for every bit-clock falling edge.
module rf_tx_bitclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ext_clk,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic             txclk_in,
  output logic             txclk_out,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             clk_q, clk_d;
  logic             sync1_q, sync2_q, prev_q;
  logic             wrap;

  assign wrap = (cnt_q >= cfg_half);

  always_comb begin
    if (cfg_ext_clk) begin
      cnt_d = '0;
      clk_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      clk_d = ~clk_q;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
      clk_d = clk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      clk_q   <= 1'b0;
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      clk_q   <= clk_d;
      sync1_q <= txclk_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign txclk_out = clk_q;
  assign fall_tick = cfg_ext_clk ? (prev_q & ~sync2_q)
                                 : (wrap & clk_q);
endmodule

// File: rtl/rf_tx_fsm.sv
// Frame sequencer: ramp-up, byte shifting, ramp-down.
module rf_tx_fsm
  import rf_tx_serializer_pkg::*;
#(
  parameter int RAMP_W = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              buf_empty,
  input  logic [BYTE_W-1:0] buf_data,
  input  logic [RAMP_W-1:0] cfg_lead,
  input  logic [RAMP_W-1:0] cfg_lag,
  output logic              buf_pop,
  output tx_state_e         state,
  output logic              data_bit,
  output logic              last_bit
);
  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  tx_state_e         state_q, state_d;
  logic [RAMP_W-1:0] ramp_q, ramp_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              last_q, last_d;

  always_comb begin
    state_d = state_q;
    ramp_d  = ramp_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    last_d  = last_q;
    buf_pop = 1'b0;
    if (tick) begin
      case (state_q)
        ST_IDLE: begin
          if (!buf_empty) begin
            state_d = ST_RAMP_UP;
            ramp_d  = '0;
          end
        end
        ST_RAMP_UP: begin
          if (ramp_q == cfg_lead) begin
            if (!buf_empty) begin
              buf_pop = 1'b1;
              sh_d    = buf_data;
              idx_d   = '0;
              state_d = ST_DATA;
            end else begin
              state_d = ST_RAMP_DOWN;
              ramp_d  = '0;
            end
          end else begin
            ramp_d = ramp_q + RAMP_W'(1);
          end
        end
        ST_DATA: begin
          if (idx_q == LAST_IDX) begin
            if (!buf_empty) begin
              buf_pop = 1'b1;
              sh_d    = buf_data;
              idx_d   = '0;
            end else begin
              state_d = ST_RAMP_DOWN;
              ramp_d  = '0;
              last_d  = sh_q[0];
            end
          end else begin
            idx_d = idx_q + IDX_W'(1);
            sh_d  = {1'b0, sh_q[BYTE_W-1:1]};
          end
        end
        ST_RAMP_DOWN: begin
          if (ramp_q == cfg_lag) begin
            state_d = ST_IDLE;
          end else begin
            ramp_d = ramp_q + RAMP_W'(1);
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ramp_q  <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ramp_q  <= ramp_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      last_q  <= last_d;
    end
  end

  assign state    = state_q;
  assign data_bit = sh_q[0];
  assign last_bit = last_q;
endmodule

// File: rtl/rf_tx_serializer.sv
module rf_tx_serializer
  import rf_tx_serializer_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int RAMP_W = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ext_clk,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic [1:0]        cfg_idle_mode,
  input  logic              cfg_cmd_pol,
  input  logic              cfg_cmd_force,
  input  logic [RAMP_W-1:0] cfg_lead,
  input  logic [RAMP_W-1:0] cfg_lag,
  input  logic              buf_empty,
  input  logic [BYTE_W-1:0] buf_data,
  output logic              buf_pop,
  input  logic              txclk_in,
  output logic              txclk_out,
  output logic              txclk_oe,
  output logic              txd,
  output logic              txd_n,
  output logic              txcmd,
  output logic              txcmd_n
);
  logic      fall_tick;
  tx_state_e st_w;
  logic      data_bit, last_bit;
  logic      in_data, cmd_on, idle_lvl;

  rf_tx_bitclk #(.DIV_W(DIV_W)) u_clk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_ext_clk(cfg_ext_clk),
    .cfg_half   (cfg_half),
    .txclk_in   (txclk_in),
    .txclk_out  (txclk_out),
    .fall_tick  (fall_tick)
  );

  rf_tx_fsm #(.RAMP_W(RAMP_W), .BYTE_W(BYTE_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (fall_tick),
    .buf_empty(buf_empty),
    .buf_data (buf_data),
    .cfg_lead (cfg_lead),
    .cfg_lag  (cfg_lag),
    .buf_pop  (buf_pop),
    .state    (st_w),
    .data_bit (data_bit),
    .last_bit (last_bit)
  );

  // Output stage: level selection and polarity
  always_comb begin
    in_data  = (st_w == ST_DATA);
    idle_lvl = cfg_idle_mode[1] ? last_bit : cfg_idle_mode[0];
    txd      = in_data ? data_bit : idle_lvl;
    txd_n    = in_data & ~data_bit;
    cmd_on   = (st_w != ST_IDLE) | cfg_cmd_force;
    txcmd    = cfg_cmd_pol ? cmd_on : ~cmd_on;
    txcmd_n  = ~txcmd;
  end

  assign txclk_oe = ~cfg_ext_clk;
endmodule

// File: rtl/rf_tx_serializer_chk.sv
module rf_tx_serializer_chk
  import rf_tx_serializer_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      cfg_ext_clk,
  input logic [1:0] cfg_idle_mode,
  input logic      cfg_cmd_pol,
  input logic      cfg_cmd_force,
  input logic      txclk_out,
  input logic      txd,
  input logic      txd_n,
  input logic      txcmd,
  input logic      buf_pop,
  input logic      buf_empty,
  input tx_state_e st
);
  // R2: generated-clock mode, data moves only with a clock fall
  p_edge_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ext_clk && $stable(cfg_ext_clk) && $stable(cfg_idle_mode) && !$stable(txd))
      |-> $fell(txclk_out));

  // R4: a pop lines up with the clock fall that starts a byte
  p_pop_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_pop && !cfg_ext_clk) |=> $fell(txclk_out));

  // R4: never pop an empty buffer
  p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_pop |-> !buf_empty);

  // R4: pop lasts one cycle
  p_pop_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_pop |=> !buf_pop);

  // R7: inverted data is quiet outside the data phase
  p_txdn_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_DATA) |-> !txd_n);

  // R8: idle and not forced gives the inactive command level
  p_cmd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !cfg_cmd_force) |-> (txcmd == !cfg_cmd_pol));

  // R3: command active whenever a frame is in progress
  p_cmd_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |-> (txcmd == cfg_cmd_pol));
endmodule

bind rf_tx_serializer rf_tx_serializer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_ext_clk  (cfg_ext_clk),
  .cfg_idle_mode(cfg_idle_mode),
  .cfg_cmd_pol  (cfg_cmd_pol),
  .cfg_cmd_force(cfg_cmd_force),
  .txclk_out    (txclk_out),
  .txd          (txd),
  .txd_n        (txd_n),
  .txcmd        (txcmd),
  .buf_pop      (buf_pop),
  .buf_empty    (buf_empty),
  .st           (st_w)
);

// File: tb/sim_rf_tx_serializer.sv
`timescale 1ns/1ps
module sim_rf_tx_serializer;
  logic       clk, rst_n;
  logic       cfg_ext_clk;
  logic [7:0] cfg_half;
  logic [1:0] cfg_idle_mode;
  logic       cfg_cmd_pol, cfg_cmd_force;
  logic [3:0] cfg_lead, cfg_lag;
  logic       buf_empty;
  logic [7:0] buf_data;
  logic       buf_pop;
  logic       txclk_in, txclk_out, txclk_oe;
  logic       txd, txd_n, txcmd, txcmd_n;

  rf_tx_serializer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_ext_clk(cfg_ext_clk), .cfg_half(cfg_half),
    .cfg_idle_mode(cfg_idle_mode), .cfg_cmd_pol(cfg_cmd_pol),
    .cfg_cmd_force(cfg_cmd_force), .cfg_lead(cfg_lead), .cfg_lag(cfg_lag),
    .buf_empty(buf_empty), .buf_data(buf_data), .buf_pop(buf_pop),
    .txclk_in(txclk_in), .txclk_out(txclk_out), .txclk_oe(txclk_oe),
    .txd(txd), .txd_n(txd_n), .txcmd(txcmd), .txcmd_n(txcmd_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  // transmit buffer model
  logic [7:0] mem [0:15];
  int wr_ptr = 0;
  int rd_ptr = 0;
  assign buf_empty = (rd_ptr == wr_ptr);
  assign buf_data  = mem[rd_ptr % 16];
  always @(posedge clk) if (buf_pop) rd_ptr <= rd_ptr + 1;

  // external bit clock: half period of 6 system cycles
  int ext_cnt = 0;
  always @(posedge clk) begin
    if (ext_cnt == 5) begin
      ext_cnt  <= 0;
      txclk_in <= ~txclk_in;
    end else begin
      ext_cnt <= ext_cnt + 1;
    end
  end

  // monitor
  bit rec_on = 0;
  int rec_cnt = 0;
  bit rec_d [0:255];
  bit rec_n [0:255];
  bit prev_mon = 0, prev_txd = 0, prev_tco = 0;
  bit edge_bad = 0, period_bad = 0;
  int last_rise = -1, exp_period = 0, pops = 0;
  wire mon_clk = cfg_ext_clk ? txclk_in : txclk_out;
  wire cmd_act = (txcmd == cfg_cmd_pol);

  always @(negedge clk) begin
    if (rec_on) begin
      if (!prev_mon && mon_clk && cmd_act && rec_cnt < 256) begin
        rec_d[rec_cnt] = txd;
        rec_n[rec_cnt] = txd_n;
        rec_cnt++;
      end
      if (!cfg_ext_clk && (txd != prev_txd) && !(prev_tco && !txclk_out)) edge_bad = 1;
      if (!cfg_ext_clk && !prev_tco && txclk_out) begin
        if (last_rise >= 0 && (cyc - last_rise) != exp_period) period_bad = 1;
        last_rise = cyc;
      end
      if (buf_pop) pops++;
    end
    prev_mon = mon_clk;
    prev_txd = txd;
    prev_tco = txclk_out;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 150000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit idle_level(int mode, bit lastb);
    if (mode >= 2) return lastb;
    return mode[0];
  endfunction

  bit exp_d [0:255];
  bit exp_n [0:255];
  bit last_sent = 0;

  task automatic run_frame(int n, int lead, int lag, int half, bit ext, int mode, bit pol);
    logic [7:0] bytes [0:15];
    int exp_cnt = 0;
    int bitcyc;
    int guard;
    int bad_idx;
    bit lvl0, lvl1, new_last;
    string tag;
    tag = ext ? "R10" : "R3";
    @(negedge clk);
    cfg_ext_clk   = ext;
    cfg_half      = 8'(half);
    cfg_lead      = 4'(lead);
    cfg_lag       = 4'(lag);
    cfg_idle_mode = 2'(mode);
    cfg_cmd_pol   = pol;
    repeat (20) @(negedge clk);
    for (int i = 0; i < n; i++) bytes[i] = 8'($urandom);
    lvl0 = idle_level(mode, last_sent);
    new_last = (n > 0) ? bytes[n-1][7] : last_sent;
    lvl1 = idle_level(mode, new_last);
    for (int i = 0; i <= lead; i++) begin exp_d[exp_cnt] = lvl0; exp_n[exp_cnt] = 0; exp_cnt++; end
    for (int b = 0; b < n; b++)
      for (int k = 0; k < 8; k++) begin
        exp_d[exp_cnt] = bytes[b][k]; exp_n[exp_cnt] = ~bytes[b][k]; exp_cnt++;
      end
    for (int i = 0; i <= lag; i++) begin exp_d[exp_cnt] = lvl1; exp_n[exp_cnt] = 0; exp_cnt++; end
    bitcyc = ext ? 12 : 2 * (half + 1);
    exp_period = bitcyc;
    rec_cnt = 0; pops = 0; edge_bad = 0; period_bad = 0; last_rise = -1;
    rec_on = 1;
    for (int i = 0; i < n; i++) mem[(wr_ptr + i) % 16] = bytes[i];
    wr_ptr = wr_ptr + n;
    guard = 0;
    while (rd_ptr != wr_ptr && guard < 5000) begin @(negedge clk); guard++; end
    while (cmd_act && guard < 10000) begin @(negedge clk); guard++; end
    repeat (3 * bitcyc) @(negedge clk);
    rec_on = 0;
    // frame length: ramps plus data bits (R3 lead, R5 lag)
    chk(rec_cnt == exp_cnt, tag, "R5 frame length in bit times", rec_cnt, exp_cnt);
    bad_idx = -1;
    for (int i = 0; i < exp_cnt && i < rec_cnt; i++)
      if (bad_idx < 0 && rec_d[i] != exp_d[i]) bad_idx = i;
    chk(bad_idx < 0, "R4", "R6 txd stream first bad index",
        bad_idx, (bad_idx < 0) ? -1 : int'(exp_d[bad_idx]));
    bad_idx = -1;
    for (int i = 0; i < exp_cnt && i < rec_cnt; i++)
      if (bad_idx < 0 && rec_n[i] != exp_n[i]) bad_idx = i;
    chk(bad_idx < 0, "R7", "txd_n stream first bad index", bad_idx, -1);
    chk(pops == n, "R4", "pop count", pops, n);
    chk(txd == lvl1, "R6", "idle level after frame", int'(txd), int'(lvl1));
    chk(txd_n == 1'b0, "R7", "txd_n idle", int'(txd_n), 0);
    chk(txcmd == !pol && txcmd_n == pol, "R8", "inactive command after frame",
        int'({txcmd, txcmd_n}), int'({!pol, pol}));
    if (!ext) begin
      chk(!edge_bad, "R2", "data changed off a clock fall", int'(edge_bad), 0);
      chk(!period_bad, "R1", "bit clock period", int'(period_bad), 0);
      chk(txclk_oe == 1'b1, "R1", "clock drive enable internal", int'(txclk_oe), 1);
    end else begin
      chk(txclk_oe == 1'b0, "R10", "clock drive enable external", int'(txclk_oe), 0);
    end
    last_sent = new_last;
  endtask

  initial begin
    void'($urandom(32'h1234_5eed));
    rst_n = 0;
    txclk_in = 0;
    cfg_ext_clk = 0; cfg_half = 8'd1; cfg_idle_mode = 2'd0;
    cfg_cmd_pol = 1; cfg_cmd_force = 0; cfg_lead = 4'd0; cfg_lag = 4'd0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(txd == 0 && txd_n == 0, "R11", "data pins after reset", int'({txd, txd_n}), 0);
    chk(txcmd == 0 && txcmd_n == 1, "R11", "command after reset", int'({txcmd, txcmd_n}), 1);
    chk(buf_pop == 0, "R11", "no pop after reset", int'(buf_pop), 0);
    // R6 last-bit mode right after reset gives 0
    cfg_idle_mode = 2'd2;
    @(negedge clk);
    chk(txd == 0, "R6", "last-bit level after reset", int'(txd), 0);

    // directed corner cases
    run_frame(1, 0, 0, 0, 0, 0, 1);   // shortest ramps, fastest clock
    run_frame(2, 3, 2, 2, 0, 1, 1);   // idle high
    run_frame(3, 1, 1, 1, 0, 2, 0);   // last-bit, active-low command
    run_frame(1, 2, 3, 3, 0, 3, 1);   // last-bit carried over
    run_frame(2, 1, 0, 0, 1, 1, 1);   // external clock
    run_frame(1, 0, 2, 0, 1, 2, 0);   // external, last-bit

    // R9 force with empty buffer
    @(negedge clk);
    cfg_cmd_pol = 1; cfg_ext_clk = 0; cfg_idle_mode = 2'd1;
    pops = 0; rec_on = 1;
    cfg_cmd_force = 1;
    repeat (40) @(negedge clk);
    chk(txcmd == 1 && txcmd_n == 0, "R9", "forced command", int'({txcmd, txcmd_n}), 2);
    chk(pops == 0 && txd == 1 && txd_n == 0, "R9", "force starts no frame",
        int'({pops[1:0], txd, txd_n}), 2);
    cfg_cmd_pol = 0;
    @(negedge clk);
    chk(txcmd == 0, "R9", "forced active-low command", int'(txcmd), 0);
    cfg_cmd_force = 0;
    @(negedge clk);
    rec_on = 0;
    chk(txcmd == 1 && txcmd_n == 0, "R8", "release force, active-low idle",
        int'({txcmd, txcmd_n}), 2);

    // constrained random frames
    for (int f = 0; f < 14; f++) begin
      run_frame(1 + int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
                int'($urandom % 4), bit'($urandom % 3 == 0),
                int'($urandom % 4), bit'($urandom % 2));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule